// File: doc/BRIEF.md
# Channel-Scanning SAR Conversion Sequencer

This block is the digital controller of an eight-channel successive-approximation converter. It drives a trial code into an external DAC. It samples a single comparator bit that reports whether the analog input is at or above that trial. It converts the channels one after another in a fixed 80-clock frame. It steps a multiplexer address downward, wrapping from channel 0 to channel 7. At the end of each conversion it issues a one-cycle write of the 8-bit result into the slot of the channel just converted.

An active-low status output pulses at every channel boundary. The pulse is 8 clocks long. When the multiplexer moves to channel 0, the pulse stretches to 72 clocks and covers that conversion. A downstream pulse-width detector can therefore find the start of each scan. After reset, a fixed start-up wait runs before the first frame.

Top module: `scan_sar_sequencer`

## Requirements
- R1: While reset is asserted and until the start-up wait ends, `stat_n_o` is 1, `wr_en_o` is 0, `mux_sel_o` is 0 and `dac_code_o` is 0.
- R2: The first falling edge of `stat_n_o` follows the 800th rising clock edge after reset is released, and at that moment `mux_sel_o` is 7.
- R3: Each later falling edge of `stat_n_o` comes exactly 80 clocks after the previous one. `mux_sel_o` changes only together with that edge, always to the previous value minus one, with 0 followed by 7.
- R4: When the new address is not 0, `stat_n_o` stays low for exactly 8 clocks.
- R5: When the new address is 0, `stat_n_o` stays low for exactly 72 clocks.
- R6: Conversion starts 8 clocks after the status edge. Bits are tried from bit 7 down to bit 0 in slots of 8 clocks. Slot i begins at clock 8+8i with the decided upper bits, trial bit 7-i set to 1 and the lower bits 0. At clock 8, `dac_code_o` is 8'h80.
- R7: A trial bit is kept when `cmp_i` is 1, meaning the input is at or above the trial code. It is cleared when `cmp_i` is 0. With an ideal comparator the stored result equals the input code.
- R8: `wr_en_o` is high for exactly one clock per frame, 74 clocks after the status edge and so 6 clocks before the next one. During that clock, `wr_addr_o` is the channel just converted and `wr_data_o` is its final code.
- R9: `cmp_i` is sampled only on the last clock of each trial slot, at clock 8+8i+7 of the frame. Its value on every other clock has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the trial code |
| dac_code_o | output | 8 | Trial code to the external DAC |
| mux_sel_o | output | 3 | Analog multiplexer channel address |
| stat_n_o | output | 1 | Active-low boundary status pulse |
| wr_en_o | output | 1 | One-cycle result write strobe |
| wr_addr_o | output | 3 | Result slot address |
| wr_data_o | output | 8 | Converted result |

## Verification
The bench builds the block with its default parameters: an 800-clock start-up, eight channels, 8-bit codes and an 80-clock frame. With these values the real start-up length, the 0-to-7 wrap and the stretched 72-clock channel-0 pulse all occur within three full scans. A comparator model derived from per-channel input codes exercises the extreme codes 0x00 and 0xFF and codes next to the mid-scale step. One scan inverts the comparator on every clock that is not a sampling clock, which shows that only the slot-end samples matter.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

    typedef enum logic {
        PH_WAIT = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;

    // Channel address step: one below, wrapping to the top channel.
    function automatic int unsigned step_down(input int unsigned addr, input int unsigned num_ch);
        return (addr == 0) ? (num_ch - 1) : (addr - 1);
    endfunction

endpackage

// File: rtl/sarseq_startup.sv
module sarseq_startup #(
    parameter int STARTUP_CLKS = 800
) (
    input  logic clk,
    input  logic rst,
    output logic go_o
);
    import sarseq_pkg::*;

    localparam int CNT_W = (STARTUP_CLKS > 1) ? $clog2(STARTUP_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STARTUP_CLKS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        go_o = 1'b0;
        if (st_q.phase == PH_WAIT) begin
            if (st_q.cnt == LAST) begin
                go_o       = 1'b1;
                st_d.phase = PH_SCAN;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_WAIT;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sarseq_frame_timer.sv
module sarseq_frame_timer #(
    parameter int NUM_CH     = 8,
    parameter int FRAME_CLKS = 80,
    parameter int ADDR_W     = 3,
    parameter int TICK_W     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    output logic              scan_q_o,
    output logic [TICK_W-1:0] tick_q_o,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic              scan_d_o,
    output logic [TICK_W-1:0] tick_d_o,
    output logic [ADDR_W-1:0] addr_d_o
);
    import sarseq_pkg::*;

    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(FRAME_CLKS - 1);

    typedef struct packed {
        logic              scan;
        logic [TICK_W-1:0] tick;
        logic [ADDR_W-1:0] addr;
    } ft_t;

    ft_t ft_q, ft_d;

    always_comb begin
        ft_d = ft_q;
        if (!ft_q.scan) begin
            if (go_i) begin
                ft_d.scan = 1'b1;
                ft_d.tick = '0;
                ft_d.addr = ADDR_W'(step_down(int'(ft_q.addr), NUM_CH));
            end
        end else if (ft_q.tick == TICK_LAST) begin
            ft_d.tick = '0;
            ft_d.addr = ADDR_W'(step_down(int'(ft_q.addr), NUM_CH));
        end else begin
            ft_d.tick = ft_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ft_q.scan <= 1'b0;
            ft_q.tick <= '0;
            ft_q.addr <= '0;
        end else begin
            ft_q <= ft_d;
        end
    end

    assign scan_q_o = ft_q.scan;
    assign tick_q_o = ft_q.tick;
    assign addr_q_o = ft_q.addr;
    assign scan_d_o = ft_d.scan;
    assign tick_d_o = ft_d.tick;
    assign addr_d_o = ft_d.addr;

endmodule

// File: rtl/sarseq_sar_core.sv
module sarseq_sar_core #(
    parameter int DATA_W     = 8,
    parameter int TICK_W     = 7,
    parameter int CONV_START = 8,
    parameter int BIT_CLKS   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_i,
    input  logic [TICK_W-1:0] tick_i,
    input  logic              cmp_i,
    output logic [DATA_W-1:0] code_o
);
    localparam int SUB_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [TICK_W-1:0] ARM_TICK = TICK_W'(CONV_START - 1);
    localparam logic [SUB_W-1:0]  SUB_LAST = SUB_W'(BIT_CLKS - 1);

    typedef struct packed {
        logic [DATA_W-1:0] code;
        logic [IDX_W-1:0]  idx;
        logic [SUB_W-1:0]  sub;
        logic              busy;
    } sar_t;

    sar_t sar_q, sar_d;

    always_comb begin
        sar_d = sar_q;
        if (scan_i && tick_i == ARM_TICK) begin
            sar_d.code             = '0;
            sar_d.code[DATA_W-1]   = 1'b1;
            sar_d.idx              = IDX_W'(DATA_W - 1);
            sar_d.sub              = '0;
            sar_d.busy             = 1'b1;
        end else if (sar_q.busy) begin
            if (sar_q.sub == SUB_LAST) begin
                sar_d.sub             = '0;
                sar_d.code[sar_q.idx] = cmp_i;
                if (sar_q.idx == '0) begin
                    sar_d.busy = 1'b0;
                end else begin
                    sar_d.idx                 = sar_q.idx - 1'b1;
                    sar_d.code[sar_q.idx - 1'b1] = 1'b1;
                end
            end else begin
                sar_d.sub = sar_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sar_q.code <= '0;
            sar_q.idx  <= '0;
            sar_q.sub  <= '0;
            sar_q.busy <= 1'b0;
        end else begin
            sar_q <= sar_d;
        end
    end

    assign code_o = sar_q.code;

endmodule

// File: rtl/sarseq_out_gen.sv
module sarseq_out_gen #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int TICK_W    = 7,
    parameter int SHORT_LEN = 8,
    parameter int LONG_LEN  = 72,
    parameter int WR_TICK   = 74
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_d_i,
    input  logic [TICK_W-1:0] tick_d_i,
    input  logic [ADDR_W-1:0] addr_d_i,
    input  logic [ADDR_W-1:0] addr_q_i,
    input  logic [DATA_W-1:0] code_i,
    output logic              stat_n_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    typedef struct packed {
        logic              stat_n;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
    } og_t;

    og_t og_q, og_d;
    logic [TICK_W:0] low_len;

    always_comb begin
        og_d    = og_q;
        low_len = (addr_d_i == '0) ? (TICK_W+1)'(LONG_LEN) : (TICK_W+1)'(SHORT_LEN);
        og_d.stat_n = !(scan_d_i && ({1'b0, tick_d_i} < low_len));
        og_d.wr_en  = scan_d_i && (tick_d_i == TICK_W'(WR_TICK));
        if (og_d.wr_en) begin
            og_d.wr_addr = addr_q_i;
            og_d.wr_data = code_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            og_q.stat_n  <= 1'b1;
            og_q.wr_en   <= 1'b0;
            og_q.wr_addr <= '0;
            og_q.wr_data <= '0;
        end else begin
            og_q <= og_d;
        end
    end

    assign stat_n_o  = og_q.stat_n;
    assign wr_en_o   = og_q.wr_en;
    assign wr_addr_o = og_q.wr_addr;
    assign wr_data_o = og_q.wr_data;

endmodule

// File: rtl/scan_sar_sequencer.sv
module scan_sar_sequencer #(
    parameter int DATA_W       = 8,
    parameter int NUM_CH       = 8,
    parameter int FRAME_CLKS   = 80,
    parameter int STAT_CLKS    = 8,
    parameter int EXT_CLKS     = 64,
    parameter int UPD_LEAD     = 6,
    parameter int BIT_CLKS     = 8,
    parameter int STARTUP_CLKS = 800
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmp_i,
    output logic [7:0]  dac_code_o,
    output logic [2:0]  mux_sel_o,
    output logic        stat_n_o,
    output logic        wr_en_o,
    output logic [2:0]  wr_addr_o,
    output logic [7:0]  wr_data_o
);
    localparam int ADDR_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int TICK_W     = $clog2(FRAME_CLKS);
    localparam int CONV_START = STAT_CLKS;
    localparam int LONG_LEN   = STAT_CLKS + EXT_CLKS;
    localparam int WR_TICK    = FRAME_CLKS - UPD_LEAD;

    logic              go;
    logic              scan_q, scan_d;
    logic [TICK_W-1:0] tick_q, tick_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] code;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    sarseq_startup #(.STARTUP_CLKS(STARTUP_CLKS)) startup_i (
        .clk (clk),
        .rst (rst),
        .go_o(go)
    );

    sarseq_frame_timer #(
        .NUM_CH    (NUM_CH),
        .FRAME_CLKS(FRAME_CLKS),
        .ADDR_W    (ADDR_W),
        .TICK_W    (TICK_W)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .go_i    (go),
        .scan_q_o(scan_q),
        .tick_q_o(tick_q),
        .addr_q_o(addr_q),
        .scan_d_o(scan_d),
        .tick_d_o(tick_d),
        .addr_d_o(addr_d)
    );

    sarseq_sar_core #(
        .DATA_W    (DATA_W),
        .TICK_W    (TICK_W),
        .CONV_START(CONV_START),
        .BIT_CLKS  (BIT_CLKS)
    ) sar_i (
        .clk   (clk),
        .rst   (rst),
        .scan_i(scan_q),
        .tick_i(tick_q),
        .cmp_i (cmp_i),
        .code_o(code)
    );

    sarseq_out_gen #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .TICK_W   (TICK_W),
        .SHORT_LEN(STAT_CLKS),
        .LONG_LEN (LONG_LEN),
        .WR_TICK  (WR_TICK)
    ) out_i (
        .clk      (clk),
        .rst      (rst),
        .scan_d_i (scan_d),
        .tick_d_i (tick_d),
        .addr_d_i (addr_d),
        .addr_q_i (addr_q),
        .code_i   (code),
        .stat_n_o (stat_n_o),
        .wr_en_o  (wr_en_o),
        .wr_addr_o(wr_addr),
        .wr_data_o(wr_data)
    );

    assign dac_code_o = 8'(code);
    assign mux_sel_o  = 3'(addr_q);
    assign wr_addr_o  = 3'(wr_addr);
    assign wr_data_o  = 8'(wr_data);

endmodule

// File: rtl/sarseq_checker.sv
module sarseq_checker #(
    parameter int FRAME_CLKS = 80,
    parameter int STAT_CLKS  = 8,
    parameter int EXT_CLKS   = 64,
    parameter int UPD_LEAD   = 6
) (
    input logic       clk,
    input logic       rst,
    input logic       stat_n,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [2:0] mux_sel,
    input logic [7:0] dac_code
);
    localparam int CNT_W = $clog2(FRAME_CLKS + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             prev_q;
    logic             seen_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fall_now;
    logic [CNT_W-1:0] since;

    assign fall_now = prev_q && !stat_n;
    assign since    = fall_now ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= stat_n;
            if (fall_now) seen_q <= 1'b1;
            if (fall_now)            cnt_q <= CNT_W'(1);
            else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: quiet outputs before the first boundary
    a_r1_quiet_before_scan: assert property (@(posedge clk) disable iff (rst)
        !seen_q && !fall_now |-> stat_n && !wr_en && mux_sel == 3'd0);

    // R3: address steps down by one, with wrap, on each status fall
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_n) |-> mux_sel == 3'($past(mux_sel) - 3'd1));

    // R3: address is held between boundaries
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !$fell(stat_n) |-> $stable(mux_sel));

    // R4 and R5: pulse length depends on the new address
    a_r5_pulse_len: assert property (@(posedge clk) disable iff (rst)
        seen_q && $rose(stat_n) |->
            since == ((mux_sel == 3'd0) ? CNT_W'(STAT_CLKS + EXT_CLKS) : CNT_W'(STAT_CLKS)));

    // R6: first trial code is the MSB alone
    a_r6_first_trial: assert property (@(posedge clk) disable iff (rst)
        seen_q && since == CNT_W'(STAT_CLKS) |-> dac_code == 8'h80);

    // R8: write lands a fixed lead before the next boundary
    a_r8_write_lead: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> seen_q && since == CNT_W'(FRAME_CLKS - UPD_LEAD));

    // R8: write strobe lasts one clock
    a_r8_write_single: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R8: write targets the channel being converted
    a_r8_write_addr: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_addr == mux_sel);

endmodule

bind scan_sar_sequencer sarseq_checker #(
    .FRAME_CLKS(FRAME_CLKS),
    .STAT_CLKS (STAT_CLKS),
    .EXT_CLKS  (EXT_CLKS),
    .UPD_LEAD  (UPD_LEAD)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .stat_n  (stat_n_o),
    .wr_en   (wr_en_o),
    .wr_addr (wr_addr_o),
    .mux_sel (mux_sel_o),
    .dac_code(dac_code_o)
);

// File: tb/scan_sar_sequencer_tb.sv
module scan_sar_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp;
    logic       flip = 1'b0;
    logic [7:0] dac_code;
    logic [2:0] mux_sel;
    logic       stat_n;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] vin [8];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Ideal comparator: input at or above trial code, optionally inverted off-sample
    always_comb cmp = (dac_code <= vin[mux_sel]) ^ flip;

    scan_sar_sequencer dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmp_i     (cmp),
        .dac_code_o(dac_code),
        .mux_sel_o (mux_sel),
        .stat_n_o  (stat_n),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        for (int c = 0; c < 5; c++) @(negedge clk);
        check(stat_n === 1'b1, "R1 stat in reset", int'(stat_n), 1);
        check(wr_en === 1'b0, "R1 wr_en in reset", int'(wr_en), 0);
        check(mux_sel === 3'd0, "R1 mux in reset", int'(mux_sel), 0);
        check(dac_code === 8'd0, "R1 dac in reset", int'(dac_code), 0);
        rst = 1'b0;
    endtask

    task automatic t_startup();
        int k = 0;
        int bad = 0;
        while (k < 2000) begin
            @(negedge clk);
            k++;
            if (stat_n === 1'b0) break;
            if (wr_en !== 1'b0 || mux_sel !== 3'd0 || dac_code !== 8'd0) bad++;
        end
        check(bad == 0, "R1 quiet during start-up", bad, 0);
        check(k == 800, "R2 first status fall edge", k, 800);
        check(mux_sel === 3'd7, "R2 first channel", int'(mux_sel), 7);
    endtask

    // Entered at the negedge where status has just fallen (frame clock 0)
    task automatic do_frame(input int ch, input bit noise);
        int bad_stat = 0;
        int bad_addr = 0;
        int wr_cnt = 0;
        int wr_t = -1;
        logic [7:0] wd = '0;
        logic [2:0] wa = '0;
        logic [7:0] d8 = '0;
        logic [7:0] d16 = '0;
        int low_len = (ch == 0) ? 72 : 8;
        logic [7:0] exp16;
        logic [2:0] nxt;
        for (int t = 0; t < 80; t++) begin
            if (stat_n !== ((t < low_len) ? 1'b0 : 1'b1)) bad_stat++;
            if (mux_sel !== 3'(ch)) bad_addr++;
            if (wr_en === 1'b1) begin
                wr_cnt++;
                wr_t = t;
                wd = wr_data;
                wa = wr_addr;
            end
            if (t == 8)  d8  = dac_code;
            if (t == 16) d16 = dac_code;
            // R9: invert comparator except on slot-end sampling clocks
            flip = noise && !(t >= 8 && t < 72 && ((t - 8) % 8) == 7);
            @(negedge clk);
        end
        flip = 1'b0;
        exp16 = {vin[ch][7], 1'b1, 6'b0};
        nxt = (ch == 0) ? 3'd7 : 3'(ch - 1);
        if (ch == 0) check(bad_stat == 0, "R5 long status pulse", bad_stat, 0);
        else         check(bad_stat == 0, "R4 short status pulse", bad_stat, 0);
        check(bad_addr == 0, "R3 address held in frame", bad_addr, 0);
        check(d8 == 8'h80, "R6 first trial code", int'(d8), 8'h80);
        check(d16 == exp16, "R6 second trial code", int'(d16), int'(exp16));
        check(wr_cnt == 1, "R8 one write per frame", wr_cnt, 1);
        check(wr_t == 74, "R8 write clock in frame", wr_t, 74);
        check(wa == 3'(ch), "R8 write address", int'(wa), ch);
        if (noise) check(wd == vin[ch], "R9 result under off-sample noise", int'(wd), int'(vin[ch]));
        else       check(wd == vin[ch], "R7 converted result", int'(wd), int'(vin[ch]));
        check(stat_n === 1'b0, "R3 80-clock boundary period", int'(stat_n), 0);
        check(mux_sel === nxt, "R3 address step and wrap", int'(mux_sel), int'(nxt));
    endtask

    task automatic t_scan(input int pat, input bit noise);
        for (int c = 0; c < 8; c++) begin
            case (pat)
                0: vin[c] = 8'(c * 37 + 5);
                1: vin[c] = (c == 0) ? 8'h00 : (c == 1) ? 8'hFF : (c == 2) ? 8'h80 :
                            (c == 3) ? 8'h7F : (c == 4) ? 8'h01 : (c == 5) ? 8'hFE :
                            (c == 6) ? 8'h55 : 8'hAA;
                default: vin[c] = ~8'(c * 29 + 3);
            endcase
        end
        for (int ch = 7; ch >= 0; ch--) do_frame(ch, noise);
    endtask

    initial begin
        for (int c = 0; c < 8; c++) vin[c] = 8'h00;
        t_reset();
        t_startup();
        t_scan(0, 1'b0);
        t_scan(1, 1'b0);
        t_scan(2, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule